// File: doc/BRIEF.md
# Edge-Selectable Input Capture Timer

This block is a free-running up-counter that advances once every six system clocks, paired with a capture register that stores the counter whenever a chosen transition appears on a serial tape input line. A control byte chooses falling-edge, rising-edge or both-edge capture; any other value turns capture off. The tape input passes through a two-flop synchroniser before its edges are detected, and its synchronised level can be read back.

Software reads the counter and the capture register one byte at a time over a small byte-wide register bus. Reading the low byte of the live counter also takes a snapshot of the whole counter, so a following read of the high byte belongs to the same instant. Two sticky flags, one for counter wrap-around and one for capture, are driven out to an interrupt controller and cleared by writing ones to the status register.

Top module: `icap_timer`

## Requirements
- R1: After reset the counter starts at 0 and increments by one every 6 clock cycles, so after n clock edges with reset released it holds floor(n/6) modulo 2^CNT_W.
- R2: Reset clears the counter, the control byte, the capture register, the snapshot and both flags; every register then reads 0x00.
- R3: The control byte at address 0 is read and written whole; exactly 0x02 selects falling-edge capture, 0x04 rising-edge, 0x06 both edges, and any other value (including 0x00 and 0x03) performs no capture.
- R4: A read of address 2 returns counter bits 7:0 and loads the whole counter into a snapshot; a read of address 3 returns snapshot bits 15:8, not the live counter.
- R5: On a selected edge the capture register takes the counter value present two clock edges after the tape input changed (one edge per synchroniser flop); it reads as bits 7:0 at address 4 and bits 15:8 at address 5, and is unchanged by edges that are not selected.
- R6: Status register address 1 bit 0 reads the synchronised tape level, which follows the pin after two clock edges.
- R7: Each capture sets the capture flag (status bit 1, port cap_flag); writing status with bit 1 set clears it, and a capture in the same cycle as the clear wins.
- R8: A counter wrap from all ones to zero sets the overflow flag (status bit 2, port ovf_flag); it stays set until a status write with bit 2 set, and writes with bit 2 clear leave it alone.
- R9: Reads of unused addresses 6 and 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Read strobe; read data is valid in the same cycle |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the addressed register |
| tape_in | input | 1 | Asynchronous tape input line |
| cap_flag | output | 1 | Sticky capture flag |
| ovf_flag | output | 1 | Sticky counter wrap flag |

## Verification
The bench aims at the snapshot around a low-byte rollover: it reads the low byte at 0xFF, lets the counter pass 0x100, then reads the high byte, which a design returning the live counter would report as 0x01 instead of 0x00. It drives edges of the wrong polarity for each mode and the non-matching codes 0x00 and 0x03, where a loose decode would load the capture register or raise the flag. It lines a flag-clear write up with a capture in the same cycle, where a clear-priority design would lose the event, and it counts exact synchroniser latency, where a missing or extra flop shifts the captured value by one count. The wrap to zero is checked on the cycle it happens, along with the rule that a zero write leaves the overflow flag set.

// File: rtl/ictmr_pkg.sv
package ictmr_pkg;

  localparam logic [2:0] A_MODE    = 3'd0;
  localparam logic [2:0] A_STATUS  = 3'd1;
  localparam logic [2:0] A_LIVE_LO = 3'd2;
  localparam logic [2:0] A_LIVE_HI = 3'd3;
  localparam logic [2:0] A_CAP_LO  = 3'd4;
  localparam logic [2:0] A_CAP_HI  = 3'd5;

  localparam int ST_LEVEL = 0;
  localparam int ST_CAP   = 1;
  localparam int ST_OVF   = 2;

  localparam logic [7:0] MODE_FALL = 8'h02;
  localparam logic [7:0] MODE_RISE = 8'h04;
  localparam logic [7:0] MODE_BOTH = 8'h06;

  // Whether a detected transition counts as a capture event for a mode byte.
  function automatic logic edge_hit(input logic [7:0] mode, input logic rise,
                                    input logic fall);
    case (mode)
      MODE_FALL: edge_hit = fall;
      MODE_RISE: edge_hit = rise;
      MODE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

  // Next value of a sticky flag: a set in the same cycle beats a clear.
  function automatic logic sticky_next(input logic cur, input logic set,
                                       input logic clr);
    sticky_next = set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/ictmr_prescale.sv
module ictmr_prescale #(
  parameter int DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  assign tick = (phase == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    phase <= '0;
    else if (tick) phase <= '0;
    else           phase <= phase + 1'b1;
  end
endmodule

// File: rtl/ictmr_sync_edge.sv
module ictmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/ictmr_counter.sv
module ictmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  assign wrap = tick & (&count);

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= count + 1'b1;
  end
endmodule

// File: rtl/icap_timer.sv
module icap_timer
  import ictmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV         = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       tape_in,
  output logic       cap_flag,
  output logic       ovf_flag
);
  // Internal events, named for the bound checker.
  logic             tick;
  logic             wrap_evt;
  logic             edge_rise;
  logic             edge_fall;
  logic             tape_lvl;
  logic             cap_evt;
  logic             snap_evt;
  logic             clr_cap;
  logic             clr_ovf;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cap_q;
  logic [CNT_W-1:0] snap_q;
  logic [7:0]       mode_q;
  logic [15:0]      live16;
  logic [15:0]      cap16;
  logic [15:0]      snap16;

  ictmr_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  ictmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count(count), .wrap(wrap_evt)
  );

  ictmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(tape_in),
    .level(tape_lvl), .rise(edge_rise), .fall(edge_fall)
  );

  assign cap_evt  = edge_hit(mode_q, edge_rise, edge_fall);
  assign snap_evt = rd_en & (addr == A_LIVE_LO);
  assign clr_cap  = wr_en & (addr == A_STATUS) & wr_data[ST_CAP];
  assign clr_ovf  = wr_en & (addr == A_STATUS) & wr_data[ST_OVF];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      cap_q    <= '0;
      snap_q   <= '0;
      cap_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (wr_en && addr == A_MODE) mode_q <= wr_data;
      if (cap_evt)  cap_q  <= count;
      if (snap_evt) snap_q <= count;
      cap_flag <= sticky_next(cap_flag, cap_evt, clr_cap);
      ovf_flag <= sticky_next(ovf_flag, wrap_evt, clr_ovf);
    end
  end

  always_comb begin
    live16 = '0;
    cap16  = '0;
    snap16 = '0;
    live16[CNT_W-1:0] = count;
    cap16[CNT_W-1:0]  = cap_q;
    snap16[CNT_W-1:0] = snap_q;
  end

  always_comb begin
    case (addr)
      A_MODE:    rd_data = mode_q;
      A_STATUS:  rd_data = {5'b0, ovf_flag, cap_flag, tape_lvl};
      A_LIVE_LO: rd_data = live16[7:0];
      A_LIVE_HI: rd_data = snap16[15:8];
      A_CAP_LO:  rd_data = cap16[7:0];
      A_CAP_HI:  rd_data = cap16[15:8];
      default:   rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/icap_timer_chk.sv
module icap_timer_chk
  import ictmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wrap_evt,
  input logic             edge_rise,
  input logic             edge_fall,
  input logic             cap_evt,
  input logic             snap_evt,
  input logic             clr_cap,
  input logic             clr_ovf,
  input logic             cap_flag,
  input logic             ovf_flag,
  input logic [7:0]       mode_q,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cap_q,
  input logic [CNT_W-1:0] snap_q
);
  a_r1_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  a_r1_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> count == CNT_W'($past(count) + 1'b1));

  a_r3_no_capture_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_FALL && mode_q != MODE_RISE && mode_q != MODE_BOTH) |-> !cap_evt);

  a_r3_one_edge_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({edge_rise, edge_fall}));

  a_r4_snapshot_loads: assert property (@(posedge clk) disable iff (!rst_n)
    snap_evt |=> snap_q == $past(count));

  a_r5_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_q == $past(count));

  a_r5_capture_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap_q));

  a_r7_cap_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_flag);

  a_r7_cap_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cap && !cap_evt) |=> !cap_flag);

  a_r8_ovf_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ovf_flag && count == '0);

  a_r8_ovf_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_ovf) |=> ovf_flag);
endmodule

bind icap_timer icap_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wrap_evt(wrap_evt),
  .edge_rise(edge_rise), .edge_fall(edge_fall), .cap_evt(cap_evt),
  .snap_evt(snap_evt), .clr_cap(clr_cap), .clr_ovf(clr_ovf),
  .cap_flag(cap_flag), .ovf_flag(ovf_flag), .mode_q(mode_q),
  .count(count), .cap_q(cap_q), .snap_q(snap_q)
);

// File: tb/test_icap_timer.sv
module test_icap_timer;
  localparam int CW = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       tape_in = 1'b0;
  logic       cap_flag;
  logic       ovf_flag;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  icap_timer #(.CNT_W(CW)) i_icap_timer (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .tape_in(tape_in),
    .cap_flag(cap_flag), .ovf_flag(ovf_flag)
  );

  always @(posedge clk) if (rst_n) cyc = cyc + 1;

  // Counter value the bench expects after n clock edges out of reset.
  function automatic int live(input int n);
    live = (n / 6) % (1 << CW);
  endfunction

  // Monitor: pops the expected read data and compares mid-cycle.
  always @(negedge clk) begin
    if (rd_en) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read with no expected item, got %02h", rd_data);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string      t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: addr %0d got %02h expected %02h", t, addr, rd_data, e);
        end
      end
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    addr  = a;
    rd_en = 1'b1;
    step();
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr    = a;
    wr_data = d;
    wr_en   = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic chk(input logic got, input logic e, input string t);
    checks++;
    if (got !== e) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", t, got, e);
    end
  endtask

  logic [7:0] exp_lo, exp_hi;
  int c0;

  // Drive an edge, return the counter value a capture of it should hold.
  task automatic drive_tape(input logic v, output int capv);
    tape_in = v;
    capv    = live(cyc + 2);
  endtask

  initial begin : watchdog
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : driver
    int cv, cv2;
    step(4);
    rst_n = 1'b1;
    step();
    // R2: reset state
    rd(3'd0, 8'h00, "R2");
    rd(3'd1, 8'h00, "R2");
    rd(3'd4, 8'h00, "R2");
    rd(3'd5, 8'h00, "R2");
    chk(cap_flag, 1'b0, "R2 cap_flag");
    chk(ovf_flag, 1'b0, "R2 ovf_flag");
    // R1: counting rate
    rd(3'd2, 8'(live(cyc)), "R1");
    step(31);
    rd(3'd2, 8'(live(cyc)), "R1");
    step(5);
    rd(3'd2, 8'(live(cyc)), "R1");
    // R9: unused addresses
    rd(3'd6, 8'h00, "R9");
    rd(3'd7, 8'h00, "R9");
    // R6 with capture off (mode 0): level latency, R3 no capture
    tape_in = 1'b1;
    step();
    rd(3'd1, 8'h00, "R6 before sync");
    rd(3'd1, 8'h01, "R6 level high");
    tape_in = 1'b0;
    step(3);
    rd(3'd1, 8'h00, "R3 mode 0 no capture");
    // R3: code 0x03 does not capture
    wr(3'd0, 8'h03);
    rd(3'd0, 8'h03, "R3 readback");
    tape_in = 1'b1; step(4);
    tape_in = 1'b0; step(4);
    rd(3'd1, 8'h00, "R3 mode 3 no flag");
    rd(3'd4, 8'h00, "R3 mode 3 no capture");
    // R3/R5: falling only
    wr(3'd0, 8'h02);
    tape_in = 1'b1; step(4);
    rd(3'd1, 8'h01, "R3 fall mode ignores rise");
    step(7);
    drive_tape(1'b0, cv);
    step(4);
    rd(3'd1, 8'h02, "R7 flag after fall");
    chk(cap_flag, 1'b1, "R7 cap_flag port");
    rd(3'd4, 8'(cv), "R5 fall cap lo");
    rd(3'd5, 8'(cv >> 8), "R5 fall cap hi");
    // R8 zero-bit write leaves capture flag, R7 clear
    wr(3'd1, 8'h04);
    rd(3'd1, 8'h02, "R7 wrong-bit write keeps flag");
    wr(3'd1, 8'h02);
    rd(3'd1, 8'h00, "R7 clear");
    // R3/R5: rising only
    wr(3'd0, 8'h04);
    step(9);
    drive_tape(1'b1, cv);
    step(4);
    rd(3'd1, 8'h03, "R7 flag after rise");
    wr(3'd1, 8'h02);
    step(13);
    tape_in = 1'b0; step(4);
    rd(3'd1, 8'h00, "R3 rise mode ignores fall");
    rd(3'd4, 8'(cv), "R5 rise cap lo held");
    // R3: both edges
    wr(3'd0, 8'h06);
    drive_tape(1'b1, cv);
    step(4);
    rd(3'd4, 8'(cv), "R5 both rise cap lo");
    wr(3'd1, 8'h02);
    step(20);
    drive_tape(1'b0, cv2);
    step(4);
    rd(3'd1, 8'h02, "R3 both fall flag");
    rd(3'd4, 8'(cv2), "R5 both fall cap lo");
    // R7: set beats clear in the same cycle
    drive_tape(1'b1, cv);
    step(2);
    wr(3'd1, 8'h02);
    rd(3'd1, 8'h03, "R7 set wins over clear");
    rd(3'd4, 8'(cv), "R5 cap at set-wins edge");
    // R4: snapshot across low-byte rollover
    while (!(live(cyc) == 8'hFF && (cyc % 6) == 0)) step();
    rd(3'd2, 8'hFF, "R4 live lo at ff");
    step(11);
    rd(3'd3, 8'h00, "R4 hi from snapshot");
    rd(3'd2, 8'(live(cyc)), "R4 live lo after roll");
    rd(3'd3, 8'h01, "R4 hi new snapshot");
    // R8: wrap to zero
    while (cyc < 6 * (1 << CW) - 1) step();
    chk(ovf_flag, 1'b0, "R8 before wrap");
    step();
    chk(ovf_flag, 1'b1, "R8 at wrap");
    rd(3'd2, 8'h00, "R8 counter zero");
    wr(3'd1, 8'h02);
    chk(ovf_flag, 1'b1, "R8 bit2 clear write keeps");
    rd(3'd1, 8'h05, "R8 status ovf");
    wr(3'd1, 8'h04);
    rd(3'd1, 8'h01, "R8 cleared");
    chk(ovf_flag, 1'b0, "R8 port cleared");
    step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule